// File: doc/BRIEF.md
# Card-Interface Operation Control Register

This block is the 8-bit operation control register of a multimedia card host controller. Software writes it over a simple synchronous register port to do two things. It can force an abort of a command sequence that is already under way, and it can restart read data reception after the read path has stalled. The stall comes either from a full receive FIFO or from a block boundary in a multi-block read. The register also holds one plain data-enable bit. It mirrors four status lines from the sequencers so that software can read them back.

The two command bits are write-one-to-trigger. A write of 1 is taken only while its protocol window is open; at any other time it is dropped. Once taken, a request is held as a level on an output toward its sequencer until that sequencer returns a one-cycle acknowledge. A pending abort is also withdrawn if the command sequence goes idle before the acknowledge arrives. Readback is combinational from the stored bits and the live status lines.

Top module: `opctl_reg`

## Requirements
- R1: After a synchronous active-low reset, the stored bits 7, 5 and 4 are 0 and the outputs `abort_req`, `resume_req` and `data_en` are low.
- R2: A write with bit 7 = 1 while `cmd_sent` = 1 and `seq_active` = 1 raises `abort_req` on the next clock edge, and bit 7 then reads 1.
- R3: A write with bit 7 = 1 while `cmd_sent` = 0 or `seq_active` = 0 is ignored: `abort_req` and bit 7 stay 0.
- R4: A write with bit 5 = 1 while `rd_halted` = 1 raises `resume_req` on the next clock edge, and bit 5 then reads 1.
- R5: A write with bit 5 = 1 while `rd_halted` = 0 is ignored: `resume_req` and bit 5 stay 0.
- R6: Writing 0 to bit 7 or bit 5 never clears a pending request.
- R7: A pending request stays high until its acknowledge (`abort_ack` for bit 7, `resume_ack` for bit 5) is sampled high, and it is low after that edge. An acknowledge in the same cycle as a new write of 1 wins, so the bit ends up 0.
- R8: A pending abort is cleared on the edge at which `seq_active` is sampled 0, even without `abort_ack`.
- R9: Bit 6 always reads 0, and writes to it have no effect.
- R10: Bit 4 is read/write. It takes `wr_data[4]` on every write, reads back its stored value and drives `data_en`.
- R11: Bits 3..0 read back the live inputs {`seq_active`, `cmd_sent`, `rd_halted`, `halt_cause`} in that order, bit 3 first. Writes to these bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational readback |
| cmd_sent | input | 1 | Command transmission has completed |
| seq_active | input | 1 | Command sequence is in progress |
| rd_halted | input | 1 | Read reception is halted |
| halt_cause | input | 1 | Halt reason: 1 = block end, 0 = FIFO full |
| abort_ack | input | 1 | One-cycle acknowledge from the command sequencer |
| resume_ack | input | 1 | One-cycle acknowledge from the read-data path |
| abort_req | output | 1 | Held abort request |
| resume_req | output | 1 | Held resume request |
| data_en | output | 1 | Data-enable control bit |

## Verification
The hardest situations to reach from the ports are collisions at the edges of a request's life. One is an acknowledge arriving in the same cycle as a fresh write of 1. Another is the command sequence dropping idle while an abort is still pending. Directed steps set up each collision exactly once. A seeded random phase then drives the window inputs, the acknowledges and the writes independently every cycle. Because of that, window closures and acknowledges land on pending requests many times, and a bench-side model predicts every readback.

// File: rtl/opctl_pkg.sv
// Package: shared field positions and widths for the operation control register.
// Assumes an 8-bit register; the positions are fixed by software's view of the bits.
package opctl_pkg;
    localparam int REG_W      = 8;
    localparam int ABORT_POS  = 7;
    localparam int RSVD_POS   = 6;
    localparam int RESUME_POS = 5;
    localparam int DEN_POS    = 4;
    localparam int STAT_W     = 4;

    // Live status lines mirrored in the low bits of readback.
    typedef struct packed {
        logic seq_active;
        logic cmd_sent;
        logic rd_halted;
        logic halt_cause;
    } opctl_stat_t;
endpackage

// File: rtl/opctl_req_bit.sv
// Module: one write-one-to-trigger request bit with an acceptance window.
// The bit sets when a write of 1 arrives while the window is open. It clears on an
// acknowledge or, when IDLE_CLR is set, when keep drops. Clearing beats setting.
// Assumes the acknowledge is a single-cycle pulse from the target sequencer.
module opctl_req_bit #(
    parameter bit IDLE_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stb,
    input  logic win,
    input  logic ack,
    input  logic keep,
    output logic req
);
    logic clr;

    // Clear condition: an acknowledge, or the owning sequence going idle.
    always_comb begin
        clr = ack || (IDLE_CLR && !keep);
    end

    // Request state: hold until cleared, and accept new writes only in the window.
    always_ff @(posedge clk) begin
        if (!rst_n)               req <= 1'b0;
        else if (req && clr)      req <= 1'b0;
        else if (!req && set_stb && win) req <= 1'b1;
    end

    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && keep) |=> req);
    // R3
    no_set_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !(set_stb && win)) |=> !req);

    generate
        if (IDLE_CLR) begin : g_idle
            // R8
            idle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req && !keep) |=> !req);
        end
    endgenerate
endmodule

// File: rtl/opctl_readback.sv
// Module: assembles the readback word from the stored bits and the live status lines.
// The reserved bit is tied to 0 here.
module opctl_readback
    import opctl_pkg::*;
(
    input  logic        abort_bit,
    input  logic        resume_bit,
    input  logic        den_bit,
    input  opctl_stat_t stat,
    output logic [REG_W-1:0] rd_word
);
    // Field placement for readback.
    always_comb begin
        rd_word             = '0;
        rd_word[ABORT_POS]  = abort_bit;
        rd_word[RSVD_POS]   = 1'b0;
        rd_word[RESUME_POS] = resume_bit;
        rd_word[DEN_POS]    = den_bit;
        rd_word[STAT_W-1:0] = stat;
    end
endmodule

// File: rtl/opctl_reg.sv
// Module: operation control register of a card host controller (top).
// Holds the abort and resume requests, each gated by its protocol window,
// plus a plain data-enable bit. Assumes a single-cycle synchronous write strobe
// and single-cycle acknowledge pulses.
module opctl_reg
    import opctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             cmd_sent,
    input  logic             seq_active,
    input  logic             rd_halted,
    input  logic             halt_cause,
    input  logic             abort_ack,
    input  logic             resume_ack,
    output logic             abort_req,
    output logic             resume_req,
    output logic             data_en
);
    opctl_stat_t stat;
    logic abort_win, abort_stb, resume_stb;
    logic unused_wr;

    // Status bundle and write decode.
    always_comb begin
        stat       = '{seq_active: seq_active, cmd_sent: cmd_sent,
                       rd_halted: rd_halted, halt_cause: halt_cause};
        abort_win  = cmd_sent && seq_active;
        abort_stb  = wr_en && wr_data[ABORT_POS];
        resume_stb = wr_en && wr_data[RESUME_POS];
        unused_wr  = ^{wr_data[RSVD_POS], wr_data[STAT_W-1:0]};
    end

    opctl_req_bit #(.IDLE_CLR(1'b1)) u_abort (
        .clk(clk), .rst_n(rst_n), .set_stb(abort_stb), .win(abort_win),
        .ack(abort_ack), .keep(seq_active), .req(abort_req));

    opctl_req_bit #(.IDLE_CLR(1'b0)) u_resume (
        .clk(clk), .rst_n(rst_n), .set_stb(resume_stb), .win(rd_halted),
        .ack(resume_ack), .keep(1'b1), .req(resume_req));

    // Data-enable bit: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     data_en <= 1'b0;
        else if (wr_en) data_en <= wr_data[DEN_POS];
    end

    opctl_readback u_rb (
        .abort_bit(abort_req), .resume_bit(resume_req), .den_bit(data_en),
        .stat(stat), .rd_word(rd_data));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RSVD_POS] == 1'b0);
    // R5
    resume_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!resume_req && !rd_halted) |=> !resume_req);
    // R10
    den_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(data_en));
endmodule

// File: tb/sim_opctl_reg.sv
module sim_opctl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic cmd_sent = 0, seq_active = 0, rd_halted = 0, halt_cause = 0;
    logic abort_ack = 0, resume_ack = 0;
    logic abort_req, resume_req, data_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit m_ab = 0, m_co = 0, m_de = 0;

    always #10 clk = ~clk; // 50 MHz

    opctl_reg u0 (.*);

    function automatic logic [7:0] exp_rd();
        return {m_ab, 1'b0, m_co, m_de, seq_active, cmd_sent, rd_halted, halt_cause};
    endfunction

    // Next-state model from the requirements, using the inputs driven this cycle.
    function automatic void model_step();
        bit ab_n = m_ab, co_n = m_co;
        if (m_ab && (abort_ack || !seq_active)) ab_n = 0;
        else if (!m_ab && wr_en && wr_data[7] && cmd_sent && seq_active) ab_n = 1;
        if (m_co && resume_ack) co_n = 0;
        else if (!m_co && wr_en && wr_data[5] && rd_halted) co_n = 1;
        if (wr_en) m_de = wr_data[4];
        m_ab = ab_n; m_co = co_n;
    endfunction

    task automatic chk(string tag, logic [10:0] act, logic [10:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, {rd_data, abort_req, resume_req, data_en},
                 {exp_rd(), m_ab, m_co, m_de});
    endtask

    // One cycle: inputs already set at negedge; model follows the edge; compare at next negedge.
    task automatic cyc(string tag, bit we, logic [7:0] wd, bit cs, bit sa, bit rh,
                       bit hc, bit aa, bit ra);
        wr_en = we; wr_data = wd; cmd_sent = cs; seq_active = sa;
        rd_halted = rh; halt_cause = hc; abort_ack = aa; resume_ack = ra;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 0; abort_ack = 0; resume_ack = 0;
        check_all(tag);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset state");
        // R9 / R10: reserved bit ignored, data enable stored
        cyc("R9 R10 rsvd and den", 1, 8'h5F, 0, 0, 0, 0, 0, 0);
        // R3: abort outside window (no cmd_sent)
        cyc("R3 abort no cmd_sent", 1, 8'h80, 0, 1, 0, 0, 0, 0);
        cyc("R3 abort no seq_active", 1, 8'h80, 1, 0, 0, 0, 0, 0);
        // R2: accepted
        cyc("R2 abort accept", 1, 8'h80, 1, 1, 0, 0, 0, 0);
        // R6: writing 0 keeps it
        cyc("R6 write zero keeps abort", 1, 8'h00, 1, 1, 0, 0, 0, 0);
        // R7: hold without ack, then ack
        cyc("R7 abort holds", 0, 8'h00, 1, 1, 0, 0, 0, 0);
        cyc("R7 abort ack clears", 0, 8'h00, 1, 1, 0, 0, 1, 0);
        // R8: idle clear
        cyc("R2 abort re-accept", 1, 8'h80, 1, 1, 0, 0, 0, 0);
        cyc("R8 idle clears abort", 0, 8'h00, 1, 0, 0, 0, 0, 0);
        // R5: continue outside window
        cyc("R5 resume not halted", 1, 8'h20, 1, 1, 0, 1, 0, 0);
        // R4 / R11
        cyc("R4 R11 resume accept", 1, 8'h20, 0, 1, 1, 1, 0, 0);
        cyc("R6 write zero keeps resume", 1, 8'h10, 0, 0, 1, 0, 0, 0);
        // R7: ack beats simultaneous write
        cyc("R7 ack wins over write", 1, 8'h20, 0, 0, 1, 0, 0, 1);
        cyc("R11 status mirror", 0, 8'h00, 1, 0, 1, 0, 0, 0);
        // Random phase
        for (int k = 0; k < 600; k++) begin
            logic [7:0] d = 8'($urandom);
            bit we = ($urandom % 3) == 0;
            cyc("R7 random", we, d, 1'($urandom), ($urandom % 5) != 0, 1'($urandom),
                1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule